// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block drives a parallel RGB panel interface. On every pixel clock it produces horizontal sync, vertical sync, data enable and the position of the current active pixel. Each axis is set by one packed 32-bit timing word that carries a sync length and two porches. A shared size word carries the active width and height. Counting starts at the pulse width, so one scan line is sync, then back porch, then active pixels, then front porch. A frame follows the same order, counted in lines.

The pixel source is a stream that cannot be stalled. The block raises `pix_ready` for exactly the pixel clocks in which it takes a pixel, and the source must present `pix_valid` in those clocks. There is no back-pressure. The raster never waits. A clock with `pix_ready` high and `pix_valid` low flags `underflow` for that clock.

A per-frame `vsync_evt` pulse can feed an interrupt. An optional halt parks the raster at the next frame boundary. Timing words are captured only when a frame begins. Every field must be at least 1.

Top module: `raster_timer`

## Requirements
- R1: While reset is held, and while `enable` is low, `hsync`, `vsync`, `de`, `pix_ready`, `vsync_evt` and `underflow` are low, and `pos_x` and `pos_y` are zero.
- R2: The horizontal word holds three fields: sync length in bits [7:0], back porch in bits [19:8] and front porch in bits [31:20]. A line is sync, back porch, active width, front porch, and `hsync` is high for the first (sync length) clocks of each line.
- R3: The vertical word uses the same bit fields, counted in lines. `vsync` is high for the whole of the first (vertical sync length) lines of each frame.
- R4: `de` is high only when the horizontal count and the vertical count are both inside their active regions. In that case `pos_x` and `pos_y` give the offsets from the first active pixel and the first active line. When `de` is low, both positions are zero. `de` is never high together with `hsync` or `vsync`.
- R5: `vsync_evt` is high for exactly one clock, the first clock of the vertical sync period, once per frame. The frame period equals the line total times the line count.
- R6: The size word holds the active width in bits [15:0] and the active height in bits [31:16]. Any legal set of words gives a frame of (sum of horizontal fields) × (sum of vertical fields) clocks, with width × height data-enable clocks.
- R7: The timing words and the size word are captured only when a frame starts. A change made during a frame takes effect at the next frame.
- R8: `pix_ready` equals `de`. `underflow` is high in exactly the clocks where `pix_ready` is high and `pix_valid` is low. It is never high outside active video, whatever the value of `pix_valid`.
- R9: With `halt_en` high, a `halt_req` that is seen at the last clock of a frame stops the raster after that frame completes. The outputs then stay idle until `halt_req` falls, and the next frame starts on the clock after that.
- R10: With `halt_en` low, `halt_req` has no effect and the frame period is unchanged.
- R11: If `enable` is low at a clock edge, the outputs are idle from the next clock. When `enable` rises again, a new frame starts on the next clock, with `vsync_evt` and `hsync` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the raster; low forces idle |
| halt_en | input | 1 | Allows the halt request to act |
| halt_req | input | 1 | Park the raster at the next frame boundary |
| h_timing | input | 32 | Horizontal sync, back porch and front porch fields |
| v_timing | input | 32 | Vertical sync, back porch and front porch fields, in lines |
| panel_size | input | 32 | Active width (low half) and active height (high half) |
| pix_valid | input | 1 | Source has a pixel available |
| pix_ready | output | 1 | Pixel taken this clock (equals data enable) |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| pos_x | output | 16 | Active pixel column |
| pos_y | output | 16 | Active line row |
| vsync_evt | output | 1 | One-clock pulse at the start of vertical sync |
| underflow | output | 1 | Pixel needed but not valid |

## Verification
The assertions check, on every cycle, the relations between outputs that always hold:
- data enable never overlaps either sync, and the positions are zero outside it;
- the frame pulse falls inside both syncs and never lasts two clocks;
- underflow only appears while a pixel is being taken;
- a disabled block is idle one clock later.

Only the bench scenarios can show the actual lengths of the sync, porch and active regions, the frame period for different words, the frame-boundary capture of new words, and the halt sequencing.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int WORD_W  = 32;
  localparam int SYNC_W  = 8;
  localparam int PORCH_W = 12;
  localparam int SIZE_W  = 16;
  localparam int BP_LSB  = SYNC_W;
  localparam int FP_LSB  = BP_LSB + PORCH_W;
  localparam int CNT_W   = SIZE_W + 2;
  localparam int N_AXES  = 2;

  typedef struct packed {
    logic [SYNC_W-1:0]  sync;
    logic [PORCH_W-1:0] back;
    logic [SIZE_W-1:0]  active;
    logic [PORCH_W-1:0] front;
  } axis_cfg_t;

  function automatic axis_cfg_t unpack_axis(input logic [WORD_W-1:0] tw,
                                            input logic [SIZE_W-1:0] sz);
    axis_cfg_t c;
    c.sync   = tw[SYNC_W-1:0];
    c.back   = tw[BP_LSB +: PORCH_W];
    c.front  = tw[FP_LSB +: PORCH_W];
    c.active = sz;
    return c;
  endfunction
endpackage

// File: rtl/raster_axis.sv
module raster_axis
  import raster_pkg::*;
(
  input  axis_cfg_t        cfg,
  input  logic [CNT_W-1:0] cnt,
  output logic             in_sync,
  output logic             in_active,
  output logic             is_last,
  output logic [SIZE_W-1:0] offset
);
  logic [CNT_W-1:0] sync_end, act_lo, act_hi, total;

  always_comb begin
    sync_end  = CNT_W'(cfg.sync);
    act_lo    = sync_end + CNT_W'(cfg.back);
    act_hi    = act_lo + CNT_W'(cfg.active);
    total     = act_hi + CNT_W'(cfg.front);
    in_sync   = cnt < sync_end;
    in_active = (cnt >= act_lo) && (cnt < act_hi);
    is_last   = cnt == (total - CNT_W'(1));
    offset    = in_active ? SIZE_W'(cnt - act_lo) : '0;
  end
endmodule

// File: rtl/raster_seq.sv
module raster_seq #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             hold,
  input  logic             h_last,
  input  logic             v_last,
  output logic             running,
  output logic             load,
  output logic [CNT_W-1:0] h_cnt,
  output logic [CNT_W-1:0] v_cnt
);
  logic frame_end;

  assign frame_end = running && h_last && v_last;
  assign load      = enable && !hold && (!running || frame_end);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      running <= 1'b0;
      h_cnt   <= '0;
      v_cnt   <= '0;
    end else if (load) begin
      running <= 1'b1;
      h_cnt   <= '0;
      v_cnt   <= '0;
    end else if (frame_end) begin
      running <= 1'b0;
      h_cnt   <= '0;
      v_cnt   <= '0;
    end else if (running) begin
      if (h_last) begin
        h_cnt <= '0;
        v_cnt <= v_cnt + CNT_W'(1);
      end else begin
        h_cnt <= h_cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import raster_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              halt_en,
  input  logic              halt_req,
  input  logic [WORD_W-1:0] h_timing,
  input  logic [WORD_W-1:0] v_timing,
  input  logic [WORD_W-1:0] panel_size,
  input  logic              pix_valid,
  output logic              pix_ready,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [SIZE_W-1:0] pos_x,
  output logic [SIZE_W-1:0] pos_y,
  output logic              vsync_evt,
  output logic              underflow
);
  axis_cfg_t         cfg_q [N_AXES];
  axis_cfg_t         cfg_d [N_AXES];
  logic [CNT_W-1:0]  cnt_w [N_AXES];
  logic [SIZE_W-1:0] off_w [N_AXES];
  logic [N_AXES-1:0] sync_w, act_w, last_w;
  logic              running, load;

  assign cfg_d[0] = unpack_axis(h_timing, panel_size[SIZE_W-1:0]);
  assign cfg_d[1] = unpack_axis(v_timing, panel_size[2*SIZE_W-1:SIZE_W]);

  raster_seq #(.CNT_W(CNT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .hold    (halt_en && halt_req),
    .h_last  (last_w[0]),
    .v_last  (last_w[1]),
    .running (running),
    .load    (load),
    .h_cnt   (cnt_w[0]),
    .v_cnt   (cnt_w[1])
  );

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    always_ff @(posedge clk) begin
      if (!rst_n)    cfg_q[a] <= '0;
      else if (load) cfg_q[a] <= cfg_d[a];
    end

    raster_axis u_axis (
      .cfg       (cfg_q[a]),
      .cnt       (cnt_w[a]),
      .in_sync   (sync_w[a]),
      .in_active (act_w[a]),
      .is_last   (last_w[a]),
      .offset    (off_w[a])
    );
  end

  always_comb begin
    hsync     = running && sync_w[0];
    vsync     = running && sync_w[1];
    de        = running && act_w[0] && act_w[1];
    pos_x     = de ? off_w[0] : '0;
    pos_y     = de ? off_w[1] : '0;
    vsync_evt = running && (cnt_w[0] == '0) && (cnt_w[1] == '0);
    pix_ready = de;
    underflow = de && !pix_valid;
  end
endmodule

// File: rtl/raster_timer_chk.sv
module raster_timer_chk
  import raster_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              pix_ready,
  input logic              hsync,
  input logic              vsync,
  input logic              de,
  input logic [SIZE_W-1:0] pos_x,
  input logic [SIZE_W-1:0] pos_y,
  input logic              vsync_evt,
  input logic              underflow
);
  // R4
  de_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (!hsync && !vsync));

  // R4
  pos_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (pos_x == '0 && pos_y == '0));

  // R5
  evt_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_evt |-> (hsync && vsync));

  // R5
  evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_evt |=> !vsync_evt);

  // R8
  underflow_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (de && pix_ready));

  // R11
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!hsync && !vsync && !de && !vsync_evt));
endmodule

bind raster_timer raster_timer_chk u_chk (.*);

// File: tb/tb_raster_timer.sv
`timescale 1ns/1ps
module tb_raster_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, halt_en = 1'b0, halt_req = 1'b0, pix_valid = 1'b1;
  logic [31:0] h_timing, v_timing, panel_size;
  logic        pix_ready, hsync, vsync, de, vsync_evt, underflow;
  logic [15:0] pos_x, pos_y;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  raster_timer dut (.*);

  function automatic logic [31:0] tword(int s, int b, int f);
    return (32'(f) << 20) | (32'(b) << 8) | 32'(s);
  endfunction

  // config A: line 2+3+4+2 = 11, frame 1+2+3+1 = 7 lines
  localparam logic [31:0] HA = 32'h0020_0302, VA = 32'h0010_0201, PA = 32'h0003_0004;
  // config B: line 1+1+2+1 = 5, frame 2+1+2+1 = 6 lines
  localparam logic [31:0] HB = 32'h0010_0101, VB = 32'h0010_0102, PB = 32'h0002_0002;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_evt();
    for (int i = 0; i < 1000 && !vsync_evt; i++) step();
  endtask

  task automatic period(output int n, output int nde);
    n = 0; nde = 0;
    do begin
      if (de) nde++;
      step(); n++;
    end while (!vsync_evt && n < 1000);
  endtask

  task automatic check_idle(input string req);
    check(req, {hsync, vsync, de, pix_ready, vsync_evt, underflow}, 0);
    check(req, {pos_x, pos_y}, 0);
  endtask

  task automatic t_reset();
    step();
    check_idle("R1 reset");
    rst_n = 1'b1;
    step(); step();
    check_idle("R1 disabled");
  endtask

  task automatic t_start();
    enable = 1'b1;
    step();
    check("R11 start evt", vsync_evt, 1);
    check("R11 start hsync", hsync, 1);
  endtask

  task automatic t_frame_a();
    for (int c = 0; c < 77; c++) begin
      int h = c % 11, v = c / 11;
      bit ed = (h >= 5 && h < 9) && (v >= 3 && v < 6);
      check("R2 hsync", hsync, int'(h < 2));
      check("R3 vsync", vsync, int'(v < 1));
      check("R4 de", de, int'(ed));
      check("R4 pos_x", pos_x, ed ? h - 5 : 0);
      check("R4 pos_y", pos_y, ed ? v - 3 : 0);
      check("R5 evt", vsync_evt, int'(c == 0));
      step();
    end
    check("R5 next frame evt", vsync_evt, 1);
  endtask

  task automatic t_reprogram();
    int n, nde;
    wait_evt();
    h_timing = HB; v_timing = VB; panel_size = PB;
    period(n, nde);
    check("R7 old period kept", n, 77);
    check("R7 old de count", nde, 12);
    period(n, nde);
    check("R6 new period", n, 30);
    check("R6 new de count", nde, 4);
    h_timing = HA; v_timing = VA; panel_size = PA;
    period(n, nde);
    check("R7 B frame finishes", n, 30);
    period(n, nde);
    check("R7 A restored", n, 77);
  endtask

  task automatic t_underflow();
    for (int i = 0; i < 200 && !de; i++) step();
    pix_valid = 1'b0; #1;
    check("R8 underflow in active", underflow, 1);
    check("R8 ready equals de", pix_ready, 1);
    for (int i = 0; i < 200 && de; i++) step();
    check("R8 no underflow blank", underflow, 0);
    pix_valid = 1'b1;
    for (int i = 0; i < 200 && !de; i++) step();
    check("R8 valid no underflow", underflow, 0);
  endtask

  task automatic t_halt_ignored();
    int n, nde;
    wait_evt();
    halt_en = 1'b0; halt_req = 1'b1;
    period(n, nde);
    check("R10 period unchanged", n, 77);
    halt_req = 1'b0;
  endtask

  task automatic t_halt();
    int seen = 0;
    wait_evt();
    halt_en = 1'b1; halt_req = 1'b1;
    for (int c = 1; c < 77; c++) begin
      step();
      if (vsync_evt) seen++;
    end
    check("R9 frame completes", seen, 0);
    check("R9 last line active", hsync, 0);
    step();
    for (int i = 0; i < 20; i++) begin
      check_idle("R9 parked");
      step();
    end
    halt_req = 1'b0;
    step();
    check("R9 restart evt", vsync_evt, 1);
    halt_en = 1'b0;
  endtask

  task automatic t_disable();
    wait_evt();
    for (int i = 0; i < 10; i++) step();
    enable = 1'b0;
    step();
    for (int i = 0; i < 5; i++) begin
      check_idle("R11 disabled idle");
      step();
    end
    enable = 1'b1;
    step();
    check("R11 re-enable evt", vsync_evt, 1);
    check("R11 re-enable hsync", hsync, 1);
  endtask

  initial begin
    h_timing = HA; v_timing = VA; panel_size = PA;
    t_reset();
    t_start();
    t_frame_a();
    t_reprogram();
    t_underflow();
    t_halt_ignored();
    t_halt();
    t_disable();
    wait_evt();
    t_frame_a();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule